// File: doc/BRIEF.md
# I2C Master Control and Status Register File

This block is the byte-wide register file that sits between a host bus and the transfer engine of an I2C master controller. It holds the control byte handed to the engine, the mode byte with its global interrupt enable, the status byte, the extended status byte, the interrupt mask, the transfer count, the extended control byte with its soft-reset action, the line-control byte, the clock divider and the master and slave address bytes. Writes take effect on the next clock edge. Reads are combinational and have no side effects. The data queue and the bus signalling live elsewhere. The queue's full and non-empty flags and the engine's done, error and halt events come in as inputs.

A small transfer tracker has two states. `XS_IDLE` is the start-up state. The transition *launch* (`XS_IDLE` to `XS_RUN`) happens on a control write with bit 0 set, and it raises `start_o` for that cycle. The transition *finish* (`XS_RUN` to `XS_IDLE`) happens on a done, error or halt event. The transition *abort* (any state to `XS_IDLE`) happens on a soft reset. The status pending bit is high exactly while the tracker is in `XS_RUN`.

The interrupt output is a level. It rises together with the interrupt-active status bit when an enabled and unmasked event occurs. It stays high until software clears it through the status register while the global enable is set.

Top module: `i2cr_regs`

## Requirements
- R1: After reset, every offset in 0..31 reads 0, except offset 9, which reads 0x40 with the bus idle, and offset 16, which reads 0x0F; `irq_o` and `start_o` are 0.
- R2: A write to offset 7 (mode) stores the value AND 0x3D. Bit 2 of this register is the global interrupt enable. When written bit 6 is 1, `flush_o` is 1 during the cycle of that write.
- R3: A write to offset 14 (transfer count) stores the value AND 0x77. A done event loads bits 2:0 with `evt_count`, clears bit 3 and keeps bits 6:4.
- R4: Offsets 4, 5, 10, 11, 12 and 13 store the full byte. Offset 16 stores the value AND 0x0F and drives `line_o`. `madr_o` is {offset 5, offset 4}.
- R5: The status byte at offset 8 is {0, 0, queue non-empty, queue full, 0, error, interrupt active, pending}. A write to it clears only the bits set in value AND 0x0A, so the error bit survives a write of 0xFF.
- R6: A status write with bit 1 set clears the interrupt-active bit. It lowers `irq_o` only when the global enable is set; otherwise `irq_o` holds.
- R7: Offset 9 reads bits 7:4 live as 5 while `bus_busy` is 1 and as 4 while it is 0. Bit 0 is an abort flag that is set by an error event. A write clears the low-nibble bits set in value AND 0x8F.
- R8: A write to offset 15 with bit 0 set restores every register to its reset value, lowers `irq_o` and returns the tracker to `XS_IDLE`, except offsets 4, 5, 10 and 11, which keep their contents.
- R9: A control write with bit 0 set in `XS_IDLE` pulses `start_o` and sets pending until a done, error or halt event. The same write in `XS_RUN` gives no pulse. An accepted start clears the error bit.
- R10: The interrupt is raised only while the global enable is set, by one of three unmasked sources: a done event with a non-zero `evt_count` (mask bit 0), an error event (mask bit 2) or a halt event (mask bit 3).
- R11: A write to offset 6 (control) stores the value AND 0xFE and drives `ctl_o`.
- R12: When an interrupt event and a status clear of bit 1 arrive in the same cycle, the event wins: the interrupt-active bit and `irq_o` end up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 5 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| bus_busy | input | 1 | Live bus-busy state from the engine |
| evt_done | input | 1 | Transfer finished, one-cycle pulse |
| evt_count | input | 3 | Bytes moved by the finished transfer |
| evt_error | input | 1 | Transfer error, one-cycle pulse |
| evt_halt | input | 1 | Transfer halted, one-cycle pulse |
| q_full | input | 1 | Data queue full |
| q_nonempty | input | 1 | Data queue holds data |
| start_o | output | 1 | Launch pulse to the engine |
| flush_o | output | 1 | Queue flush pulse |
| ctl_o | output | 8 | Stored control byte |
| madr_o | output | 16 | Master address bytes {high, low} |
| clkdiv_o | output | 8 | Clock divider byte |
| line_o | output | 4 | Line-control nibble |
| irq_o | output | 1 | Level interrupt |

## Verification
Every offset is read after reset, and the same all-offset read is repeated after a soft reset with non-reset values planted everywhere. The difference between the two read-outs separates preserved registers from reinitialised ones. All 256 byte values are written to the mode, count and line-control registers, and each read-back is compared against the value AND its mask; this catches any wrong mask bit. The interrupt path is swept over all 16 mask values, the three event sources and both enable states, which separates source-to-mask wiring errors from enable gating errors. Further sequences cover the ordering corner cases: a clear with the enable off, a clear and an event in the same cycle, a start while a transfer is running, and the live bus-state code.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int unsigned REG_AW = 5;
    localparam int unsigned REG_DW = 8;
    localparam int unsigned CNT_W  = 3;

    localparam logic [REG_AW-1:0] OFS_MADR_LO = 5'd4;
    localparam logic [REG_AW-1:0] OFS_MADR_HI = 5'd5;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 5'd6;
    localparam logic [REG_AW-1:0] OFS_MODE    = 5'd7;
    localparam logic [REG_AW-1:0] OFS_STAT    = 5'd8;
    localparam logic [REG_AW-1:0] OFS_XSTAT   = 5'd9;
    localparam logic [REG_AW-1:0] OFS_SADR_LO = 5'd10;
    localparam logic [REG_AW-1:0] OFS_SADR_HI = 5'd11;
    localparam logic [REG_AW-1:0] OFS_CLKDIV  = 5'd12;
    localparam logic [REG_AW-1:0] OFS_IMASK   = 5'd13;
    localparam logic [REG_AW-1:0] OFS_XCNT    = 5'd14;
    localparam logic [REG_AW-1:0] OFS_XCTL    = 5'd15;
    localparam logic [REG_AW-1:0] OFS_LINE    = 5'd16;

    localparam logic [REG_DW-1:0] CTRL_KEEP = 8'hFE;
    localparam logic [REG_DW-1:0] MODE_KEEP = 8'h3D;
    localparam logic [REG_DW-1:0] STAT_W1C  = 8'h0A;
    localparam logic [REG_DW-1:0] XSTAT_W1C = 8'h8F;
    localparam logic [REG_DW-1:0] XCNT_KEEP = 8'h77;
    localparam logic [REG_DW-1:0] XCTL_W1C  = 8'hF0;
    localparam logic [REG_DW-1:0] LINE_KEEP = 8'h0F;
    localparam logic [REG_DW-1:0] LINE_RST  = 8'h0F;

    localparam logic [3:0] BUS_CODE_BUSY = 4'h5;
    localparam logic [3:0] BUS_CODE_FREE = 4'h4;

    localparam int unsigned MODE_EINT_BIT  = 2;
    localparam int unsigned MODE_FLUSH_BIT = 6;
    localparam int unsigned MASK_DONE_BIT  = 0;
    localparam int unsigned MASK_ERR_BIT   = 2;
    localparam int unsigned MASK_HALT_BIT  = 3;

    typedef enum logic [0:0] {
        XS_IDLE = 1'b0,
        XS_RUN  = 1'b1
    } xfer_state_t;

endpackage

// File: rtl/i2cr_xfer_fsm.sv
module i2cr_xfer_fsm
    import i2cr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic go_req,
    input  logic evt_done,
    input  logic evt_error,
    input  logic evt_halt,
    output logic start_o,
    output logic pending_o
);

    xfer_state_t state_q;
    xfer_state_t state_d;
    logic        ends;

    assign ends = evt_done | evt_error | evt_halt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: launch, finish, abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (go_req) state_d = XS_RUN;
            XS_RUN:  if (ends)   state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
        if (soft_rst) state_d = XS_IDLE;
    end

    // outputs
    always_comb begin
        start_o   = 1'b0;
        pending_o = 1'b0;
        unique case (state_q)
            XS_IDLE: start_o   = go_req & ~soft_rst;
            XS_RUN:  pending_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/i2cr_irq_ctl.sv
module i2cr_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic eint,
    input  logic raise,
    input  logic clear_req,
    output logic active_o,
    output logic line_o
);

    logic active_q;
    logic line_q;

    // event wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            line_q   <= 1'b0;
        end else if (soft_rst) begin
            active_q <= 1'b0;
            line_q   <= 1'b0;
        end else begin
            if (raise) begin
                active_q <= 1'b1;
                line_q   <= 1'b1;
            end else if (clear_req) begin
                active_q <= 1'b0;
                if (eint) line_q <= 1'b0;
            end
        end
    end

    assign active_o = active_q;
    assign line_o   = line_q;

endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              bus_busy,
    input  logic              evt_done,
    input  logic [CNT_W-1:0]  evt_count,
    input  logic              evt_error,
    input  logic              evt_halt,
    input  logic              q_full,
    input  logic              q_nonempty,
    output logic              start_o,
    output logic              flush_o,
    output logic [REG_DW-1:0] ctl_o,
    output logic [2*REG_DW-1:0] madr_o,
    output logic [REG_DW-1:0] clkdiv_o,
    output logic [3:0]        line_o,
    output logic              irq_o
);

    logic [REG_DW-1:0] madr_lo_q, madr_hi_q, sadr_lo_q, sadr_hi_q;
    logic [REG_DW-1:0] ctl_q, mode_q, clkdiv_q, imask_q, cnt_q, xctl_q, line_q;
    logic [REG_DW-1:0] cnt_d;
    logic [3:0]        xsts_q, xsts_d;
    logic              err_q;

    logic wr_ctrl, wr_mode, wr_stat, wr_xstat, wr_clkdiv, wr_imask;
    logic wr_xcnt, wr_xctl, wr_line;
    logic soft_rst, go_req, pend, irqa, raise, eint;

    assign wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_mode   = reg_wr && (reg_addr == OFS_MODE);
    assign wr_stat   = reg_wr && (reg_addr == OFS_STAT);
    assign wr_xstat  = reg_wr && (reg_addr == OFS_XSTAT);
    assign wr_clkdiv = reg_wr && (reg_addr == OFS_CLKDIV);
    assign wr_imask  = reg_wr && (reg_addr == OFS_IMASK);
    assign wr_xcnt   = reg_wr && (reg_addr == OFS_XCNT);
    assign wr_xctl   = reg_wr && (reg_addr == OFS_XCTL);
    assign wr_line   = reg_wr && (reg_addr == OFS_LINE);

    assign soft_rst = wr_xctl && reg_wdata[0];
    assign go_req   = wr_ctrl && reg_wdata[0];
    assign eint     = mode_q[MODE_EINT_BIT];

    assign raise = eint & ~soft_rst &
                   ((evt_done  && (evt_count != '0) && imask_q[MASK_DONE_BIT]) |
                    (evt_error && imask_q[MASK_ERR_BIT]) |
                    (evt_halt  && imask_q[MASK_HALT_BIT]));

    i2cr_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .go_req    (go_req),
        .evt_done  (evt_done),
        .evt_error (evt_error),
        .evt_halt  (evt_halt),
        .start_o   (start_o),
        .pending_o (pend)
    );

    i2cr_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .eint      (eint),
        .raise     (raise),
        .clear_req (wr_stat && ((reg_wdata & STAT_W1C) != '0) && reg_wdata[1]),
        .active_o  (irqa),
        .line_o    (irq_o)
    );

    // next values of the fields with both software and event writers
    always_comb begin
        cnt_d = cnt_q;
        if (wr_xcnt) cnt_d = reg_wdata & XCNT_KEEP;
        if (evt_done) cnt_d = {cnt_d[REG_DW-1:4], 1'b0, evt_count};
        xsts_d = xsts_q;
        if (wr_xstat) xsts_d = xsts_q & ~(reg_wdata[3:0] & XSTAT_W1C[3:0]);
        if (evt_error) xsts_d[0] = 1'b1;
    end

    // address bytes survive the soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            madr_lo_q <= '0;
            madr_hi_q <= '0;
            sadr_lo_q <= '0;
            sadr_hi_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_MADR_LO) madr_lo_q <= reg_wdata;
            if (reg_addr == OFS_MADR_HI) madr_hi_q <= reg_wdata;
            if (reg_addr == OFS_SADR_LO) sadr_lo_q <= reg_wdata;
            if (reg_addr == OFS_SADR_HI) sadr_hi_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            mode_q   <= '0;
            clkdiv_q <= '0;
            imask_q  <= '0;
            cnt_q    <= '0;
            xctl_q   <= '0;
            line_q   <= LINE_RST;
            xsts_q   <= '0;
            err_q    <= 1'b0;
        end else if (soft_rst) begin
            ctl_q    <= '0;
            mode_q   <= '0;
            clkdiv_q <= '0;
            imask_q  <= '0;
            cnt_q    <= '0;
            xctl_q   <= '0;
            line_q   <= LINE_RST;
            xsts_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            if (wr_ctrl)   ctl_q    <= reg_wdata & CTRL_KEEP;
            if (wr_mode)   mode_q   <= reg_wdata & MODE_KEEP;
            if (wr_clkdiv) clkdiv_q <= reg_wdata;
            if (wr_imask)  imask_q  <= reg_wdata;
            if (wr_xctl)   xctl_q   <= xctl_q & ~(reg_wdata & XCTL_W1C);
            if (wr_line)   line_q   <= reg_wdata & LINE_KEEP;
            cnt_q  <= cnt_d;
            xsts_q <= xsts_d;
            if (evt_error)    err_q <= 1'b1;
            else if (start_o) err_q <= 1'b0;
        end
    end

    // side-effect-free read mux
    always_comb begin
        case (reg_addr)
            OFS_MADR_LO: reg_rdata = madr_lo_q;
            OFS_MADR_HI: reg_rdata = madr_hi_q;
            OFS_CTRL:    reg_rdata = ctl_q;
            OFS_MODE:    reg_rdata = mode_q;
            OFS_STAT:    reg_rdata = {2'b00, q_nonempty, q_full, 1'b0, err_q, irqa, pend};
            OFS_XSTAT:   reg_rdata = {(bus_busy ? BUS_CODE_BUSY : BUS_CODE_FREE), xsts_q};
            OFS_SADR_LO: reg_rdata = sadr_lo_q;
            OFS_SADR_HI: reg_rdata = sadr_hi_q;
            OFS_CLKDIV:  reg_rdata = clkdiv_q;
            OFS_IMASK:   reg_rdata = imask_q;
            OFS_XCNT:    reg_rdata = cnt_q;
            OFS_XCTL:    reg_rdata = xctl_q;
            OFS_LINE:    reg_rdata = line_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign flush_o  = wr_mode && reg_wdata[MODE_FLUSH_BIT];
    assign ctl_o    = ctl_q;
    assign madr_o   = {madr_hi_q, madr_lo_q};
    assign clkdiv_o = clkdiv_q;
    assign line_o   = line_q[3:0];

endmodule

// File: rtl/i2cr_regs_chk.sv
module i2cr_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] mode_q,
    input logic [7:0] cnt_q,
    input logic       pend,
    input logic       soft_rst,
    input logic       start_o,
    input logic       irq_o,
    input logic       bus_busy,
    input logic [4:0] reg_addr,
    input logic [7:0] reg_rdata
);

    p_mode_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q & 8'hC2) == 8'h00);

    p_cnt_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q & 8'h88) == 8'h00);

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !mode_q[2] && !soft_rst) |=> irq_o);

    p_bus_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'd9) |-> (reg_rdata[7:4] == (bus_busy ? 4'h5 : 4'h4)));

    p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_q == 8'h00 && !irq_o && !pend));

    p_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> pend);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mode_q[2]));

endmodule

bind i2cr_regs i2cr_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .cnt_q     (cnt_q),
    .pend      (pend),
    .soft_rst  (soft_rst),
    .start_o   (start_o),
    .irq_o     (irq_o),
    .bus_busy  (bus_busy),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/i2cr_regs_tb_top.sv
module i2cr_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        bus_busy = 1'b0;
    logic        evt_done = 1'b0;
    logic [2:0]  evt_count = '0;
    logic        evt_error = 1'b0;
    logic        evt_halt = 1'b0;
    logic        q_full = 1'b0;
    logic        q_nonempty = 1'b0;
    logic        start_o, flush_o, irq_o;
    logic [7:0]  ctl_o, clkdiv_o;
    logic [15:0] madr_o;
    logic [3:0]  line_o;

    int  n_run = 0;
    int  n_fail = 0;
    logic last_start, last_flush;
    logic [7:0] rv;

    always #4 clk = ~clk;

    i2cr_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_busy(bus_busy),
        .evt_done(evt_done), .evt_count(evt_count), .evt_error(evt_error),
        .evt_halt(evt_halt), .q_full(q_full), .q_nonempty(q_nonempty),
        .start_o(start_o), .flush_o(flush_o), .ctl_o(ctl_o), .madr_o(madr_o),
        .clkdiv_o(clkdiv_o), .line_o(line_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        #1;
        last_start = start_o;
        last_flush = flush_o;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ev(input logic dn, input logic [2:0] c, input logic er, input logic hl);
        @(negedge clk);
        evt_done = dn; evt_count = c; evt_error = er; evt_halt = hl;
        @(negedge clk);
        evt_done = 1'b0; evt_count = '0; evt_error = 1'b0; evt_halt = 1'b0;
    endtask

    function automatic int reset_val(input int a);
        if (a == 9)  return 8'h40;
        if (a == 16) return 8'h0F;
        return 0;
    endfunction

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset image
        for (int a = 0; a < 32; a++) begin
            rd(a[4:0], rv);
            chk($sformatf("R1 offset %0d", a), rv, reset_val(a));
        end
        chk("R1 irq_o", irq_o, 0);
        chk("R1 start_o", start_o, 0);

        // R2: mode mask and flush pulse
        for (int v = 0; v < 256; v++) begin
            wr(5'd7, v[7:0]);
            rd(5'd7, rv);
            chk("R2 mode readback", rv, v & 8'h3D);
            chk("R2 flush pulse", last_flush, (v >> 6) & 1);
        end
        wr(5'd7, 8'h00);

        // R3: count mask
        for (int v = 0; v < 256; v++) begin
            wr(5'd14, v[7:0]);
            rd(5'd14, rv);
            chk("R3 count readback", rv, v & 8'h77);
        end

        // R4: line control, full-byte registers
        for (int v = 0; v < 256; v++) begin
            wr(5'd16, v[7:0]);
            rd(5'd16, rv);
            chk("R4 line readback", rv, v & 8'h0F);
            chk("R4 line_o", line_o, v & 4'hF);
        end
        for (int v = 1; v < 256; v += 37) begin
            wr(5'd4, v[7:0]);
            wr(5'd5, ~v[7:0]);
            wr(5'd12, v[7:0] ^ 8'h5A);
            chk("R4 madr_o", madr_o, {~v[7:0], v[7:0]});
            chk("R4 clkdiv_o", clkdiv_o, (v ^ 8'h5A) & 8'hFF);
            rd(5'd5, rv);
            chk("R4 madr hi read", rv, (~v) & 8'hFF);
        end

        // R11, R9: control store and launch
        wr(5'd6, 8'hFF);
        chk("R9 start pulse", last_start, 1);
        rd(5'd6, rv);
        chk("R11 ctl read", rv, 8'hFE);
        chk("R11 ctl_o", ctl_o, 8'hFE);
        rd(5'd8, rv);
        chk("R9 pending set", rv, 8'h01);
        wr(5'd6, 8'h01);
        chk("R9 no pulse while running", last_start, 0);
        ev(1'b1, 3'd0, 1'b0, 1'b0);
        rd(5'd8, rv);
        chk("R9 pending cleared", rv, 8'h00);

        // R9: accepted start clears error
        ev(1'b0, 3'd0, 1'b1, 1'b0);
        rd(5'd8, rv);
        chk("R9 error set", rv, 8'h04);
        wr(5'd6, 8'h01);
        rd(5'd8, rv);
        chk("R9 error cleared by start", rv, 8'h01);
        ev(1'b1, 3'd1, 1'b0, 1'b0);

        // R7: live bus code and abort flag
        wr(5'd9, 8'h0F);
        bus_busy = 1'b1;
        rd(5'd9, rv);
        chk("R7 busy code", rv, 8'h50);
        bus_busy = 1'b0;
        ev(1'b0, 3'd0, 1'b1, 1'b0);
        rd(5'd9, rv);
        chk("R7 abort flag", rv, 8'h41);
        wr(5'd9, 8'h0E);
        rd(5'd9, rv);
        chk("R7 unmatched clear", rv, 8'h41);
        bus_busy = 1'b1;
        rd(5'd9, rv);
        chk("R7 busy with abort", rv, 8'h51);
        bus_busy = 1'b0;
        wr(5'd9, 8'h01);
        rd(5'd9, rv);
        chk("R7 abort cleared", rv, 8'h40);

        // R5: status layout and restricted clear
        q_full = 1'b1; q_nonempty = 1'b1;
        rd(5'd8, rv);
        chk("R5 status layout", rv, 8'h34);
        wr(5'd8, 8'hFF);
        rd(5'd8, rv);
        chk("R5 error survives clear", rv, 8'h34);
        q_full = 1'b0; q_nonempty = 1'b0;

        // R10: sources x mask x enable sweep
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 16; m++) begin
                for (int s = 0; s < 3; s++) begin
                    int bitpos;
                    int exp_irq;
                    bitpos = (s == 0) ? 0 : (s == 1) ? 2 : 3;
                    exp_irq = en & ((m >> bitpos) & 1);
                    wr(5'd7, 8'h04);
                    wr(5'd8, 8'h02);
                    wr(5'd13, m[7:0]);
                    if (en == 0) wr(5'd7, 8'h00);
                    ev(s == 0, 3'd1, s == 1, s == 2);
                    chk($sformatf("R10 irq en=%0d m=%0d s=%0d", en, m, s), irq_o, exp_irq);
                    rd(5'd8, rv);
                    chk("R10 active bit", (rv >> 1) & 1, exp_irq);
                end
            end
        end
        wr(5'd7, 8'h04);
        wr(5'd8, 8'h02);
        wr(5'd13, 8'h01);
        wr(5'd14, 8'h70);
        ev(1'b1, 3'd0, 1'b0, 1'b0);
        chk("R10 zero count no irq", irq_o, 0);
        ev(1'b1, 3'd5, 1'b0, 1'b0);
        chk("R10 done irq", irq_o, 1);
        rd(5'd14, rv);
        chk("R3 count load", rv, 8'h75);

        // R6: clear with enable off holds line
        wr(5'd7, 8'h00);
        wr(5'd8, 8'h02);
        rd(5'd8, rv);
        chk("R6 active bit cleared", (rv >> 1) & 1, 0);
        chk("R6 line held", irq_o, 1);
        wr(5'd7, 8'h04);
        wr(5'd8, 8'h02);
        chk("R6 line lowered", irq_o, 0);

        // R12: event beats same-cycle clear
        ev(1'b1, 3'd1, 1'b0, 1'b0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd8; reg_wdata = 8'h02;
        evt_done = 1'b1; evt_count = 3'd1;
        @(negedge clk);
        reg_wr = 1'b0; evt_done = 1'b0; evt_count = '0;
        chk("R12 irq_o", irq_o, 1);
        rd(5'd8, rv);
        chk("R12 active bit", (rv >> 1) & 1, 1);

        // R8: soft reset
        wr(5'd4, 8'hA5);
        wr(5'd5, 8'h3C);
        wr(5'd10, 8'h11);
        wr(5'd11, 8'h22);
        wr(5'd12, 8'h99);
        wr(5'd16, 8'h05);
        wr(5'd13, 8'hFF);
        wr(5'd6, 8'h11);
        ev(1'b0, 3'd0, 1'b1, 1'b0);
        wr(5'd15, 8'h01);
        for (int a = 0; a < 32; a++) begin
            int e;
            e = (a == 4) ? 8'hA5 : (a == 5) ? 8'h3C :
                (a == 10) ? 8'h11 : (a == 11) ? 8'h22 : reset_val(a);
            rd(a[4:0], rv);
            chk($sformatf("R8 offset %0d", a), rv, e);
        end
        chk("R8 irq_o lowered", irq_o, 0);
        chk("R8 line_o", line_o, 4'hF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule